// File: doc/BRIEF.md
# I2C Transmit FIFO Burst Engine

This block holds outgoing bytes for an I2C master and feeds them, one at a time, to the byte shifter that drives the bus. Software writes up to 64 bytes through a data port. The engine then hands them over back to back, with no per-byte software handshake, and reads the acknowledge after every byte. When the last byte's acknowledge slot has finished, the block reports that it has drained. If a target answers with a NAK, the burst stops at once and the remaining bytes wait until software discards them.

A small control register turns the FIFO on and can empty it in one cycle. Three sticky event bits report the events: a NAK, a completed drain, and a push that was lost to a full FIFO. Software clears each bit by writing a one to it. The handoff to the shifter is a valid/ready offer. The shifter then returns a done pulse with the acknowledge value, and only one byte is ever on the bus at a time.

Top module: `i2c_txfifo_burst`

## Requirements
- R1: After reset the control readback is 0x00, the FIFO status has bit 4 (empty) set, the event vector is 0x00 and no byte is offered.
- R2: Bytes pushed while the FIFO is enabled are offered in push order. An offered byte stays on `sh_data` with `sh_valid` high until `sh_ready` takes it.
- R3: A data write while the FIFO is disabled (control bit 6 clear) stores nothing and is never offered.
- R4: A push to a FIFO that holds 64 bytes is dropped and sets event bit 2 (overflow). The bytes already stored are sent unchanged.
- R5: When a byte completes with an ACK and no bytes remain, FIFO status bit 4 rises and event bit 1 (drained) is set.
- R6: FIFO status bit 4 stays clear while a byte taken by the shifter still awaits its acknowledge slot.
- R7: A NAK sets event bit 0 and `line_nak`. No further byte is offered until a flush, and the unsent bytes stay counted, so status bit 4 stays clear.
- R8: Writing control bit 7 empties the FIFO in one cycle, discards pending bytes and releases the NAK stop. Bit 7 reads back as 0, and bit 6 takes the written enable value.
- R9: `line_nak` shows the acknowledge of the most recently completed byte: 1 for NAK, 0 for ACK.
- R10: Writing a 1 to a bit of `irq_clr` clears that event bit only (bit 0 NAK, bit 1 drained, bit 2 overflow). The other event bits stay unchanged.
- R11: At most one byte is in flight: `sh_valid` is low from the moment a byte is taken until its done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Write strobe for the FIFO control register |
| ctl_wdata | input | 8 | Control write data: bit 6 enable, bit 7 flush |
| ctl_rdata | output | 8 | Control readback: bit 6 enable, other bits 0 |
| dat_wr | input | 1 | Data write strobe (push) |
| dat_wdata | input | 8 | Byte to push |
| fifo_stat | output | 8 | FIFO status: bit 4 drained-and-idle |
| irq_stat | output | 8 | Sticky events: bit 0 NAK, bit 1 drained, bit 2 overflow |
| irq_clr | input | 8 | Write-one-to-clear mask for `irq_stat` |
| line_nak | output | 1 | Acknowledge value of the last completed byte |
| sh_valid | output | 1 | Byte offered to the shifter |
| sh_data | output | 8 | Offered byte |
| sh_ready | input | 1 | Shifter takes the offered byte |
| sh_done | input | 1 | Acknowledge slot of the taken byte finished |
| sh_nak | input | 1 | Qualified by `sh_done`: 1 means the target did not acknowledge |

## Verification
The hardest situation to reach is a NAK in the middle of a burst with bytes still queued behind it, and then the recovery from it. The bench's shifter model NAKs a chosen byte by its global index. The bench then waits, checks that the queued bytes stay in the scoreboard and are never offered, flushes them and sends a fresh burst. The overflow case needs 64 bytes held back. The shifter model has a pause switch, so the bench fills the FIFO completely before any byte leaves. The drain flag is checked while the last byte sits between handoff and acknowledge.

// File: rtl/txb_pkg.sv
package txb_pkg;
  localparam int CTL_EN_BIT    = 6;
  localparam int CTL_FLUSH_BIT = 7;
  localparam int FST_EMPTY_BIT = 4;
  localparam int IRQ_NAK_BIT   = 0;
  localparam int IRQ_DRAIN_BIT = 1;
  localparam int IRQ_OVF_BIT   = 2;

  typedef enum logic [1:0] {SQ_IDLE, SQ_OFFER, SQ_WAIT} seq_state_e;

  // next value of a sticky event bit: a new event wins over a clear
  function automatic logic sticky_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/txb_store.sv
module txb_store #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] level,
  output logic          full
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  function automatic logic [AW-1:0] ptr_step(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push) wptr <= ptr_step(wptr);
      if (pop)  rptr <= ptr_step(rptr);
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign head = mem[rptr];
  assign full = (level == CW'(DEPTH));
endmodule

// File: rtl/txb_seq.sv
module txb_seq
  import txb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          enable,
  input  logic          have_data,
  input  logic [DW-1:0] head,
  input  logic          sh_ready,
  input  logic          sh_done,
  input  logic          sh_nak,
  output logic          sh_valid,
  output logic [DW-1:0] sh_data,
  output logic          pop,
  output logic          done_ok,
  output logic          done_nak,
  output logic          in_flight,
  output logic          halted
);
  seq_state_e state, state_nx;

  assign sh_valid  = (state == SQ_OFFER);
  assign sh_data   = head;
  assign in_flight = (state == SQ_WAIT);
  assign pop       = sh_valid && sh_ready && !flush;
  assign done_ok   = in_flight && sh_done && !sh_nak;
  assign done_nak  = in_flight && sh_done && sh_nak;

  always_comb begin
    state_nx = state;
    unique case (state)
      SQ_IDLE:  if (have_data && enable && !halted && !flush) state_nx = SQ_OFFER;
      SQ_OFFER: if (flush) state_nx = SQ_IDLE;
                else if (sh_ready) state_nx = SQ_WAIT;
      SQ_WAIT:  if (sh_done) state_nx = SQ_IDLE;
      default:  state_nx = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      halted <= 1'b0;
    end else begin
      state <= state_nx;
      if (done_nak)   halted <= 1'b1;
      else if (flush) halted <= 1'b0;
    end
  end
endmodule

// File: rtl/txb_status.sv
module txb_status
  import txb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_nak,
  input  logic       ev_drain,
  input  logic       ev_ovf,
  input  logic [2:0] clr,
  input  logic       byte_done,
  input  logic       byte_nak,
  output logic [2:0] events,
  output logic       line_nak
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      events   <= '0;
      line_nak <= 1'b0;
    end else begin
      events[IRQ_NAK_BIT]   <= sticky_next(events[IRQ_NAK_BIT],   ev_nak,   clr[IRQ_NAK_BIT]);
      events[IRQ_DRAIN_BIT] <= sticky_next(events[IRQ_DRAIN_BIT], ev_drain, clr[IRQ_DRAIN_BIT]);
      events[IRQ_OVF_BIT]   <= sticky_next(events[IRQ_OVF_BIT],   ev_ovf,   clr[IRQ_OVF_BIT]);
      if (byte_done) line_nak <= byte_nak;
    end
  end
endmodule

// File: rtl/i2c_txfifo_burst.sv
module i2c_txfifo_burst
  import txb_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic [7:0]    ctl_wdata,
  output logic [7:0]    ctl_rdata,
  input  logic          dat_wr,
  input  logic [DW-1:0] dat_wdata,
  output logic [7:0]    fifo_stat,
  output logic [7:0]    irq_stat,
  input  logic [7:0]    irq_clr,
  output logic          line_nak,
  output logic          sh_valid,
  output logic [DW-1:0] sh_data,
  input  logic          sh_ready,
  input  logic          sh_done,
  input  logic          sh_nak
);
  logic          fifo_en;
  logic          flush_req;
  logic          push_ok, push_drop, pop;
  logic [DW-1:0] head;
  logic [CW-1:0] level;
  logic          full, have_data;
  logic          done_ok, done_nak, in_flight, halted;
  logic          drained_ev;
  logic [2:0]    events;
  logic          unused_bits;

  assign unused_bits = ^{ctl_wdata[5:0], irq_clr[7:3]};

  assign flush_req = ctl_wr && ctl_wdata[CTL_FLUSH_BIT];
  assign push_ok   = dat_wr && fifo_en && !full;
  assign push_drop = dat_wr && fifo_en && full;
  assign have_data = (level != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fifo_en <= 1'b0;
    else if (ctl_wr) fifo_en <= ctl_wdata[CTL_EN_BIT];
  end

  txb_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush_req),
    .push(push_ok), .push_data(dat_wdata), .pop(pop),
    .head(head), .level(level), .full(full)
  );

  txb_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .flush(flush_req), .enable(fifo_en),
    .have_data(have_data), .head(head),
    .sh_ready(sh_ready), .sh_done(sh_done), .sh_nak(sh_nak),
    .sh_valid(sh_valid), .sh_data(sh_data), .pop(pop),
    .done_ok(done_ok), .done_nak(done_nak),
    .in_flight(in_flight), .halted(halted)
  );

  assign drained_ev = done_ok && !have_data && !push_ok && !flush_req;

  txb_status u_status (
    .clk(clk), .rst_n(rst_n),
    .ev_nak(done_nak), .ev_drain(drained_ev), .ev_ovf(push_drop),
    .clr(irq_clr[2:0]),
    .byte_done(done_ok || done_nak), .byte_nak(done_nak),
    .events(events), .line_nak(line_nak)
  );

  always_comb begin
    ctl_rdata = '0;
    ctl_rdata[CTL_EN_BIT] = fifo_en;
    fifo_stat = '0;
    fifo_stat[FST_EMPTY_BIT] = !have_data && !in_flight;
    irq_stat = {5'b0, events};
  end
endmodule

// File: rtl/i2c_txfifo_burst_chk.sv
module i2c_txfifo_burst_chk #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_wr,
  input logic [7:0]    ctl_wdata,
  input logic [7:0]    ctl_rdata,
  input logic          dat_wr,
  input logic [7:0]    fifo_stat,
  input logic [7:0]    irq_stat,
  input logic          sh_valid,
  input logic [DW-1:0] sh_data,
  input logic          sh_ready,
  input logic          in_flight,
  input logic          halted,
  input logic [CW-1:0] level
);
  logic flushing;
  assign flushing = ctl_wr && ctl_wdata[7];

  AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    sh_valid && !sh_ready && !flushing |=> sh_valid && $stable(sh_data)); // R2
  AST_DISABLED_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr && !ctl_rdata[6] && !flushing |=> level <= $past(level)); // R3
  AST_FULL_DROP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr && ctl_rdata[6] && level == CW'(DEPTH) && !flushing |=> irq_stat[2]); // R4
  AST_BUSY_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    in_flight |-> !fifo_stat[4]); // R6
  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !sh_valid); // R7
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flushing |=> level == '0); // R8
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    in_flight |-> !sh_valid); // R11
endmodule

bind i2c_txfifo_burst i2c_txfifo_burst_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
  .ctl_rdata(ctl_rdata), .dat_wr(dat_wr), .fifo_stat(fifo_stat),
  .irq_stat(irq_stat), .sh_valid(sh_valid), .sh_data(sh_data),
  .sh_ready(sh_ready), .in_flight(in_flight), .halted(halted), .level(level)
);

// File: tb/i2c_txfifo_burst_bench.sv
`timescale 1ns/1ps
module i2c_txfifo_burst_bench;
  localparam int LAT = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic [7:0] ctl_rdata;
  logic       dat_wr = 1'b0;
  logic [7:0] dat_wdata = '0;
  logic [7:0] fifo_stat, irq_stat;
  logic [7:0] irq_clr = '0;
  logic       line_nak, sh_valid;
  logic [7:0] sh_data;
  logic       sh_ready = 1'b0, sh_done = 1'b0, sh_nak = 1'b0;

  int checks = 0, errors = 0;
  int sent_n = 0;
  int nak_at = -1;
  bit shf_go = 1'b0;
  bit finished = 1'b0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  i2c_txfifo_burst u_i2c_txfifo_burst (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .dat_wr(dat_wr), .dat_wdata(dat_wdata),
    .fifo_stat(fifo_stat), .irq_stat(irq_stat), .irq_clr(irq_clr),
    .line_nak(line_nak), .sh_valid(sh_valid), .sh_data(sh_data),
    .sh_ready(sh_ready), .sh_done(sh_done), .sh_nak(sh_nak)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic push_byte(logic [7:0] b, bit expect_sent);
    @(negedge clk);
    dat_wr = 1'b1; dat_wdata = b;
    if (expect_sent) exp_q.push_back(b);
    @(negedge clk);
    dat_wr = 1'b0;
  endtask

  task automatic ctl_write(logic [7:0] v);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = v;
    if (v[7]) exp_q.delete();
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic clear_irq(logic [7:0] m);
    @(negedge clk);
    irq_clr = m;
    @(negedge clk);
    irq_clr = '0;
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && fifo_stat[4]) break;
    end
  endtask

  // shifter model and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      sh_ready = 1'b0; sh_done = 1'b0; sh_nak = 1'b0;
      if (shf_go && sh_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected byte offered", sh_data, 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(sh_data == e, "R2 byte order", sh_data, e);
        end
        sh_ready = 1'b1;
        @(negedge clk);
        sh_ready = 1'b0;
        check(sh_valid == 1'b0, "R11 no offer while in flight", sh_valid, 0);
        repeat (LAT) @(negedge clk);
        check(fifo_stat[4] == 1'b0, "R6 empty low during ack slot", fifo_stat[4], 0);
        sh_done = 1'b1;
        sh_nak  = (sent_n == nak_at);
        sent_n++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ctl_rdata == 8'h00, "R1 control readback", ctl_rdata, 8'h00);
    check(fifo_stat == 8'h10, "R1 fifo status", fifo_stat, 8'h10);
    check(irq_stat == 8'h00, "R1 events", irq_stat, 8'h00);
    check(sh_valid == 1'b0, "R1 no offer", sh_valid, 0);
    shf_go = 1'b1;

    // R3 pushes while disabled
    push_byte(8'hA1, 1'b0);
    push_byte(8'hA2, 1'b0);
    ctl_write(8'h40);
    check(ctl_rdata == 8'h40, "R8 enable readback", ctl_rdata, 8'h40);
    repeat (30) @(negedge clk);
    check(fifo_stat[4] == 1'b1, "R3 disabled pushes not stored", fifo_stat[4], 1);

    // R2 R5 basic burst, filled while shifter paused
    shf_go = 1'b0;
    for (int i = 0; i < 5; i++) push_byte(8'h10 + 8'(i * 7), 1'b1);
    check(fifo_stat[4] == 1'b0, "R5 not empty with bytes queued", fifo_stat[4], 0);
    check(irq_stat[1] == 1'b0, "R5 no drain event yet", irq_stat[1], 0);
    shf_go = 1'b1;
    wait_drain();
    check(exp_q.size() == 0, "R2 all bytes sent", exp_q.size(), 0);
    check(fifo_stat[4] == 1'b1, "R5 empty after drain", fifo_stat[4], 1);
    check(irq_stat[1] == 1'b1, "R5 drain event", irq_stat[1], 1);
    check(line_nak == 1'b0, "R9 ack after clean burst", line_nak, 0);
    clear_irq(8'h02);
    check(irq_stat[1] == 1'b0, "R10 drain event cleared", irq_stat[1], 0);

    // R4 overflow
    shf_go = 1'b0;
    for (int i = 0; i < 64; i++) push_byte(8'(i * 3 + 1), 1'b1);
    check(irq_stat[2] == 1'b0, "R4 no overflow at 64", irq_stat[2], 0);
    push_byte(8'hEE, 1'b0);
    check(irq_stat[2] == 1'b1, "R4 overflow event", irq_stat[2], 1);
    shf_go = 1'b1;
    wait_drain();
    check(exp_q.size() == 0, "R4 stored bytes sent", exp_q.size(), 0);
    check(fifo_stat[4] == 1'b1, "R4 empty after drain, dropped byte absent", fifo_stat[4], 1);

    // R7 NAK mid burst
    nak_at = sent_n + 2;
    shf_go = 1'b0;
    for (int i = 0; i < 6; i++) push_byte(8'h60 + 8'(i), 1'b1);
    shf_go = 1'b1;
    repeat (80) @(negedge clk);
    check(irq_stat[0] == 1'b1, "R7 nak event", irq_stat[0], 1);
    check(line_nak == 1'b1, "R9 line_nak after nak", line_nak, 1);
    check(exp_q.size() == 3, "R7 no bytes after nak", exp_q.size(), 3);
    check(fifo_stat[4] == 1'b0, "R7 unsent bytes remain", fifo_stat[4], 0);
    check(sh_valid == 1'b0, "R7 engine stopped", sh_valid, 0);
    nak_at = -1;
    ctl_write(8'hC0);
    check(fifo_stat[4] == 1'b1, "R8 flush empties in one cycle", fifo_stat[4], 1);
    check(ctl_rdata == 8'h40, "R8 flush bit reads 0", ctl_rdata, 8'h40);
    check(irq_stat[0] == 1'b1, "R10 nak bit sticky", irq_stat[0], 1);
    clear_irq(8'h04);
    check(irq_stat == 8'h03, "R10 only overflow cleared", irq_stat, 8'h03);
    clear_irq(8'h07);
    check(irq_stat == 8'h00, "R10 all cleared", irq_stat, 8'h00);

    // R8 restart after flush, R9 ack restored
    push_byte(8'h5A, 1'b1);
    push_byte(8'hA5, 1'b1);
    wait_drain();
    check(exp_q.size() == 0, "R8 sends resume after flush", exp_q.size(), 0);
    check(line_nak == 1'b0, "R9 line_nak back to ack", line_nak, 0);

    // R8 flush discards pending bytes
    shf_go = 1'b0;
    for (int i = 0; i < 3; i++) push_byte(8'h90 + 8'(i), 1'b1);
    ctl_write(8'hC0);
    shf_go = 1'b1;
    repeat (30) @(negedge clk);
    check(fifo_stat[4] == 1'b1, "R8 flushed bytes not sent", fifo_stat[4], 1);

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule